// File: doc/BRIEF.md
# Probabilistic Neighbour Row Refresher

This block sits beside a DRAM controller and watches the stream of row-close (precharge) events. On every close it compares a pseudo-random 16-bit value against a programmable threshold. When the random value falls below the threshold, it queues a request to activate one row that sits next to the row just closed. Activating that row refreshes it. The aim is to limit disturbance errors that repeated activations of one row cause in the rows beside it. Per-row activation counters are not needed. A threshold near 328 gives a trigger chance of about one in two hundred per close. Raising the threshold gives stronger protection at the cost of more extra activates.

The controller takes the queued requests through a ready/valid handshake. The queue is small. A request that arrives while the queue is full is discarded, and a saturating counter records the loss. The random source is a maximal-length 16-bit LFSR. Software may load its seed, and the block never lets the seed become all zeros.

Top module: `nbrRefresher`

## Requirements
- R1: After reset, reqValid is 0, overflowCount is 0, and the LFSR holds the value 16'hACE1.
- R2: The LFSR is a right-shifting Galois register with feedback mask 16'hB400: next = (v >> 1) ^ (v[0] ? 16'hB400 : 0). It advances exactly once for each cycle with closeValid high and seedLoad low. In every other cycle it keeps its value.
- R3: A close event queues a request only when the current LFSR value, read as unsigned, is strictly less than threshold. A threshold of 0 never queues anything.
- R4: The queued row is closeRow+1 when bit 0 of the LFSR value used for the decision is 1, and closeRow-1 when that bit is 0. The queued bank equals closeBank.
- R5: Row 0 always yields row 1, and the highest row (all ones) always yields that row minus 1. The address never wraps.
- R6: When seedLoad is high, the LFSR takes seedValue, and a value of 0 is replaced by 16'h0001. A load takes priority over a step in the same cycle.
- R7: Requests leave in the order they were accepted. The queue holds 4 entries. While reqValid is high and reqReady is low, reqValid, reqBank and reqRow hold steady.
- R8: A request that arrives while the queue holds 4 entries is discarded. In that case overflowCount rises by 1 and stops at its maximum of 255.
- R9: A request accepted on a clock edge appears on reqValid/reqBank/reqRow right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load seedValue into the LFSR |
| seedValue | input | 16 | New LFSR seed (0 is replaced by 1) |
| closeValid | input | 1 | A row close (precharge) happens this cycle |
| closeBank | input | 3 | Bank of the closed row |
| closeRow | input | 14 | Address of the closed row |
| threshold | input | 16 | Trigger threshold (probability x 65536) |
| reqValid | output | 1 | A neighbour refresh request is available |
| reqReady | input | 1 | The controller takes the request |
| reqBank | output | 3 | Bank of the row to refresh |
| reqRow | output | 14 | Row to refresh |
| overflowCount | output | 8 | Saturating count of dropped requests |

## Verification
A corrupted LFSR state shows up at the first close event after the fault. Either the trigger decision or the up/down choice departs from the sequence the polynomial predicts. Because each test vector is checked one cycle after its close, the mismatch appears within a single vector. A wrong queue pointer or occupancy shows up while the queue drains, either as out-of-order rows or as a valid with no pending request. A wrong full flag shows up as an overflow count that does not match the number of requests beyond four.

// File: rtl/nbrRefresherPkg.sv
package nbrRefresherPkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic drop;
    logic step;
    logic load;
  } ctlStrobes_t;
endpackage

// File: rtl/nbrRefresherCtl.sv
module nbrRefresherCtl
  import nbrRefresherPkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             closeValid,
  input  logic             seedLoad,
  input  logic             hit,
  input  logic             reqReady,
  output ctlStrobes_t      strobes,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             reqValid
);
  logic [CNT_W-1:0] occupancy;
  logic             isFull;

  assign isFull   = (occupancy == CNT_W'(DEPTH));
  assign reqValid = (occupancy != '0);

  always_comb begin
    strobes.push = closeValid && hit && !isFull;
    strobes.drop = closeValid && hit && isFull;
    strobes.pop  = reqValid && reqReady;
    strobes.load = seedLoad;
    strobes.step = closeValid && !seedLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occupancy <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strobes.pop)  rdPtr <= rdPtr + PTR_W'(1);
      occupancy <= occupancy + CNT_W'(strobes.push) - CNT_W'(strobes.pop);
    end
  end
endmodule

// File: rtl/nbrRefresherDp.sv
module nbrRefresherDp
  import nbrRefresherPkg::*;
#(
  parameter int          ROW_W     = 14,
  parameter int          BANK_W    = 3,
  parameter int          DEPTH     = 4,
  parameter int          OVF_W     = 8,
  parameter logic [15:0] SEED_INIT = 16'hACE1,
  parameter logic [15:0] TAP_MASK  = 16'hB400,
  localparam int         PTR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [15:0]       seedValue,
  input  logic [15:0]       threshold,
  input  logic [BANK_W-1:0] closeBank,
  input  logic [ROW_W-1:0]  closeRow,
  output logic              hit,
  output logic [BANK_W-1:0] reqBank,
  output logic [ROW_W-1:0]  reqRow,
  output logic [OVF_W-1:0]  overflowCount
);
  logic [15:0]       lfsr;
  logic [15:0]       lfsrNext;
  logic [ROW_W-1:0]  nbrRow;
  logic [BANK_W-1:0] bankMem [DEPTH];
  logic [ROW_W-1:0]  rowMem  [DEPTH];

  assign hit      = (lfsr < threshold);
  assign lfsrNext = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? TAP_MASK : 16'h0000);

  always_comb begin
    if (closeRow == '0)      nbrRow = ROW_W'(1);
    else if (&closeRow)      nbrRow = closeRow - ROW_W'(1);
    else if (lfsr[0])        nbrRow = closeRow + ROW_W'(1);
    else                     nbrRow = closeRow - ROW_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr          <= SEED_INIT;
      overflowCount <= '0;
    end else begin
      if (strobes.load)      lfsr <= (seedValue == 16'h0000) ? 16'h0001 : seedValue;
      else if (strobes.step) lfsr <= lfsrNext;
      if (strobes.drop && !(&overflowCount)) overflowCount <= overflowCount + OVF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      bankMem[wrPtr] <= closeBank;
      rowMem[wrPtr]  <= nbrRow;
    end
  end

  assign reqBank = bankMem[rdPtr];
  assign reqRow  = rowMem[rdPtr];
endmodule

// File: rtl/nbrRefresher.sv
module nbrRefresher
  import nbrRefresherPkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  parameter int DEPTH  = 4,
  parameter int OVF_W  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seedLoad,
  input  logic [15:0]       seedValue,
  input  logic              closeValid,
  input  logic [BANK_W-1:0] closeBank,
  input  logic [ROW_W-1:0]  closeRow,
  input  logic [15:0]       threshold,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [BANK_W-1:0] reqBank,
  output logic [ROW_W-1:0]  reqRow,
  output logic [OVF_W-1:0]  overflowCount
);
  ctlStrobes_t      strobes;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             hit;

  nbrRefresherCtl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .closeValid(closeValid), .seedLoad(seedLoad),
    .hit(hit), .reqReady(reqReady), .strobes(strobes),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .reqValid(reqValid)
  );

  nbrRefresherDp #(.ROW_W(ROW_W), .BANK_W(BANK_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .seedValue(seedValue), .threshold(threshold), .closeBank(closeBank),
    .closeRow(closeRow), .hit(hit), .reqBank(reqBank), .reqRow(reqRow),
    .overflowCount(overflowCount)
  );
endmodule

// File: rtl/nbrRefresherChecker.sv
module nbrRefresherChecker #(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  parameter int OVF_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              closeValid,
  input logic [15:0]       threshold,
  input logic              reqValid,
  input logic              reqReady,
  input logic [BANK_W-1:0] reqBank,
  input logic [ROW_W-1:0]  reqRow,
  input logic [OVF_W-1:0]  overflowCount
);
  // R7: a stalled request keeps its valid and payload
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqRow) && $stable(reqBank));

  // R3: an empty queue stays empty when the threshold is zero
  p_zero_threshold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid && !(closeValid && threshold != 16'h0000) |=> !reqValid);

  // R8: the drop counter never falls
  p_ovf_monotonic_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> overflowCount >= $past(overflowCount));

  // R8: the drop counter moves by at most one per cycle
  p_ovf_single_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (overflowCount == $past(overflowCount)) ||
             (overflowCount == $past(overflowCount) + OVF_W'(1)));

  // R8: with no close there is nothing to drop
  p_ovf_needs_close_r8: assert property (@(posedge clk) disable iff (!rstN)
    !closeValid |=> $stable(overflowCount));
endmodule

bind nbrRefresher nbrRefresherChecker #(.ROW_W(ROW_W), .BANK_W(BANK_W), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rstN(rstN), .closeValid(closeValid), .threshold(threshold),
  .reqValid(reqValid), .reqReady(reqReady), .reqBank(reqBank), .reqRow(reqRow),
  .overflowCount(overflowCount)
);

// File: tb/nbrRefresher_bench.sv
`timescale 1ns/1ps
module nbrRefresher_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seedLoad = 1'b0;
  logic [15:0] seedValue = '0;
  logic        closeValid = 1'b0;
  logic [2:0]  closeBank = '0;
  logic [13:0] closeRow = '0;
  logic [15:0] threshold = '0;
  logic        reqValid;
  logic        reqReady = 1'b1;
  logic [2:0]  reqBank;
  logic [13:0] reqRow;
  logic [7:0]  overflowCount;

  int total = 0;
  int failed = 0;
  logic [15:0] lfsrM;

  always #2.5 clk = ~clk;

  nbrRefresher u_nbrRefresher (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedValue(seedValue),
    .closeValid(closeValid), .closeBank(closeBank), .closeRow(closeRow),
    .threshold(threshold), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .overflowCount(overflowCount)
  );

  // bank, row, threshold
  localparam logic [32:0] VEC [8] = '{
    {3'd1, 14'd100,    16'hFFFF},
    {3'd2, 14'd0,      16'hFFFF},
    {3'd7, 14'h3FFF,   16'hFFFF},
    {3'd3, 14'd5000,   16'd0},
    {3'd4, 14'd77,     16'd328},
    {3'd5, 14'd1,      16'h8000},
    {3'd6, 14'h3FFE,   16'hC000},
    {3'd0, 14'd9,      16'h4000}
  };

  function automatic logic [15:0] stepM(input logic [15:0] v);
    return {1'b0, v[15:1]} ^ (v[0] ? 16'hB400 : 16'h0000);
  endfunction

  function automatic logic [13:0] nbrM(input logic [13:0] r, input logic up);
    if (r == 14'd0) return 14'd1;
    if (r == 14'h3FFF) return 14'h3FFE;
    return up ? r + 14'd1 : r - 14'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  // One close, then one idle cycle; request popped (ready=1) on the idle edge.
  task automatic closeAndCheck(input logic [2:0] b, input logic [13:0] r, input logic [15:0] t, input string tag);
    logic fire;
    logic [13:0] expRow;
    fire   = lfsrM < t;
    expRow = nbrM(r, lfsrM[0]);
    lfsrM  = stepM(lfsrM);
    closeValid = 1'b1; closeBank = b; closeRow = r; threshold = t;
    @(negedge clk);
    closeValid = 1'b0;
    chk(reqValid == fire, {tag, " R3 R9 valid"}, 32'(reqValid), 32'(fire));
    if (fire) begin
      chk(reqRow == expRow, {tag, " R4 R5 row"}, 32'(reqRow), 32'(expRow));
      chk(reqBank == b, {tag, " R4 bank"}, 32'(reqBank), 32'(b));
    end
    @(negedge clk);
    chk(reqValid == 1'b0, {tag, " R7 popped"}, 32'(reqValid), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    total++; failed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    lfsrM = 16'hACE1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqValid == 1'b0, "R1 reset valid", 32'(reqValid), 32'd0);
    chk(overflowCount == 8'd0, "R1 reset overflow", 32'(overflowCount), 32'd0);

    // Vector table, three passes; idle cycles between closes test R2 hold
    for (int i = 0; i < 24; i++) begin
      closeAndCheck(VEC[i % 8][32:30], VEC[i % 8][29:16], VEC[i % 8][15:0], "R2 vec");
      if (i % 3 == 0) repeat (2) @(negedge clk);
    end

    // R6: zero seed becomes 1
    seedLoad = 1'b1; seedValue = 16'h0000;
    @(negedge clk);
    seedLoad = 1'b0;
    lfsrM = 16'h0001;
    closeAndCheck(3'd2, 14'd10, 16'd2, "R6 zero seed");
    // R6: explicit seed, bit0=0 gives row-1
    seedLoad = 1'b1; seedValue = 16'h0002;
    @(negedge clk);
    seedLoad = 1'b0;
    lfsrM = 16'h0002;
    closeAndCheck(3'd3, 14'd50, 16'd3, "R6 seed");
    // R6: load wins over step in the same cycle
    seedLoad = 1'b1; seedValue = 16'h0004; closeValid = 1'b1; threshold = 16'd0; closeRow = 14'd5;
    @(negedge clk);
    seedLoad = 1'b0; closeValid = 1'b0;
    lfsrM = 16'h0004;
    closeAndCheck(3'd1, 14'd60, 16'd5, "R6 priority");

    // R5 edges with a seed whose bit0 points the other way
    seedLoad = 1'b1; seedValue = 16'h0002;
    @(negedge clk);
    seedLoad = 1'b0;
    lfsrM = 16'h0002;
    closeAndCheck(3'd0, 14'd0, 16'hFFFF, "R5 row0");
    seedLoad = 1'b1; seedValue = 16'h0003;
    @(negedge clk);
    seedLoad = 1'b0;
    lfsrM = 16'h0003;
    closeAndCheck(3'd0, 14'h3FFF, 16'hFFFF, "R5 rowmax");

    // R7 / R8: fill with ready low, then drain
    begin
      logic [13:0] q [$];
      int fires;
      fires = 0;
      reqReady = 1'b0;
      for (int k = 0; k < 7; k++) begin
        closeValid = 1'b1; closeBank = 3'd2; closeRow = 14'(200 + 10 * k); threshold = 16'hFFFF;
        if (lfsrM < 16'hFFFF) begin
          fires++;
          if (q.size() < 4) q.push_back(nbrM(closeRow, lfsrM[0]));
        end
        lfsrM = stepM(lfsrM);
        @(negedge clk);
      end
      closeValid = 1'b0;
      @(negedge clk);
      chk(overflowCount == 8'(fires - 4), "R8 overflow count", 32'(overflowCount), 32'(fires - 4));
      chk(reqValid == 1'b1 && reqRow == q[0], "R7 stalled head", 32'(reqRow), 32'(q[0]));
      @(negedge clk);
      chk(reqRow == q[0], "R7 stable", 32'(reqRow), 32'(q[0]));
      reqReady = 1'b1;
      for (int k = 0; k < 4; k++) begin
        chk(reqValid == 1'b1, "R7 drain valid", 32'(reqValid), 32'd1);
        chk(reqRow == q[k], "R7 order", 32'(reqRow), 32'(q[k]));
        @(negedge clk);
      end
      chk(reqValid == 1'b0, "R7 drained", 32'(reqValid), 32'd0);
    end
    finishRun();
  end
endmodule